// File: doc/BRIEF.md
# In-band PDM command word decoder

This block listens to the one-bit PDM audio stream that the channel selector has already picked. It looks for a single 8-bit word that is sent over and over with no gap in the pattern. Once that word has run long enough, the block compares it against a fixed set of command codes. A recognised code changes one field of a small configuration register. The fields are the gain setting, the sample-rate select, a low-emission modulation mode, a low-latency mode and a held mute. While any repeating word is present, the audio path is muted. This lets a command be sent during playback without an audible click. One command asks for a power-down, and that request lasts only as long as the word keeps coming.

The default configuration comes from two strap pins, which are latched during power-on reset. A clock-loss reset brings every field back to those latched defaults. Bits are counted only on cycles where the valid strobe is high, so the block runs at any ratio between the bit rate and the system clock.

Top module: `pdm_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, the straps are latched and the outputs take the defaults: `gain_sel` is 2 (5 V) if `strap_gain_hi` is 1 and 0 (3.6 V) otherwise, `fs_hi` equals `strap_fs_hi`, and `low_emi`, `low_lat`, `mute` and `sleep_req` are 0. Strap pin changes after reset have no effect.
- R2: Only cycles with `bit_valid` high advance the detector. A cycle with `bit_valid` low and `clk_lost` low leaves every output unchanged.
- R3: Each valid bit, once 8 bits are held, is compared with the bit 8 valid bits earlier. A match adds one to a run count and a mismatch clears it. The pattern locks in the cycle after the run reaches 1024 matches, which is 129 back-to-back words from an empty history. `mute` is high while locked and falls in the cycle after the first mismatching bit.
- R4: At lock, the last 8 bits are decoded at any rotation, so the byte alignment does not matter. Gain codes set `gain_sel`: 0xD2 gives 0 (3.6 V), 0xD4 gives 1 (2.5 V), 0xD8 gives 2 (5 V).
- R5: Code 0xE1 sets `low_emi` and code 0xE2 sets `low_lat`. Both stay set after the pattern ends.
- R6: Code 0xE4 sets `fs_hi` to the inverse of the latched `strap_fs_hi`.
- R7: Code 0xAA restores the R1 defaults and clears the held mute.
- R8: Code 0x66 sets a held mute. `mute` then stays high after the pattern ends, until 0xAA or a clock loss.
- R9: Code 0xAC raises `sleep_req` at lock. It stays high until the first mismatching bit and is never high without `mute`.
- R10: A locked word that matches no code at any rotation (for example 0x3A) changes no configuration field. It only mutes while it repeats.
- R11: `clk_lost` high returns all fields to the latched defaults and clears the history, run count, lock, held mute and `sleep_req`. In that cycle it takes priority over a valid bit.
- R12: Each command changes only its own field. Earlier settings of the other fields are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous power-on reset, active low; straps latched while low |
| clk_lost | input | 1 | Clock-loss reset pulse; restores latched defaults |
| bit_valid | input | 1 | Strobe marking a new PDM sample on `bit_in` |
| bit_in | input | 1 | Selected-channel PDM sample |
| strap_gain_hi | input | 1 | Strap: 1 = 5 V gain default, 0 = 3.6 V |
| strap_fs_hi | input | 1 | Strap: 1 = 128 fs default, 0 = 64 fs |
| gain_sel | output | 2 | Gain: 0 = 3.6 V, 1 = 2.5 V, 2 = 5 V |
| fs_hi | output | 1 | Sample-rate select, 1 = 128 fs |
| low_emi | output | 1 | Low-emission modulation mode |
| low_lat | output | 1 | Low-latency mode |
| mute | output | 1 | Audio mute (pattern present or held mute) |
| sleep_req | output | 1 | Power-down request while the 0xAC word repeats |

## Verification
The hardest point to reach is the exact lock boundary. From the ports, the run count cannot be seen, and stray matches with earlier stream content can start a run early. The stimulus therefore issues a clock loss to empty the history first. It then sends exactly 128 words, checks that nothing has locked, and sends one more word, which must lock on its last bit. Alignment is covered by sending a few odd bits ahead of a pattern and by leaving idle gaps inside it. The bench picks each breaking bit from its own model so that the run ends on a known bit.

// File: rtl/pdm_cmd_pkg.sv
package pdm_cmd_pkg;

    localparam int CMD_W     = 8;
    localparam int NUM_CODES = 9;

    typedef enum logic [1:0] {
        GAIN_3V6 = 2'd0,
        GAIN_2V5 = 2'd1,
        GAIN_5V0 = 2'd2
    } gain_e;

    // Index i of CODE_TAB decodes to cmd_e value i+1.
    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_GAIN_3V6,
        CMD_GAIN_2V5,
        CMD_GAIN_5V0,
        CMD_LOW_EMI,
        CMD_LOW_LAT,
        CMD_FS_FLIP,
        CMD_DEFAULTS,
        CMD_MUTE,
        CMD_SLEEP
    } cmd_e;

    localparam logic [CMD_W-1:0] CODE_TAB [NUM_CODES] = '{
        8'hD2, 8'hD4, 8'hD8, 8'hE1, 8'hE2, 8'hE4, 8'hAA, 8'h66, 8'hAC
    };

    typedef struct packed {
        gain_e gain;
        logic  fs_hi;
        logic  low_emi;
        logic  low_lat;
        logic  hold_mute;
    } cfg_t;

    function automatic cfg_t strap_cfg(input logic g_hi, input logic f_hi);
        cfg_t c;
        c.gain      = g_hi ? GAIN_5V0 : GAIN_3V6;
        c.fs_hi     = f_hi;
        c.low_emi   = 1'b0;
        c.low_lat   = 1'b0;
        c.hold_mute = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pdm_rot_match.sv
// Flags a window equal to CODE under any cyclic rotation.
module pdm_rot_match #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   CODE = '0
) (
    input  logic [W-1:0] win,
    output logic         hit
);

    logic [W-1:0] rot [W];

    for (genvar r = 0; r < W; r++) begin : g_rot
        if (r == 0) begin : g_id
            assign rot[r] = win;
        end else begin : g_sh
            assign rot[r] = {win[W-1-r:0], win[W-1:W-r]};
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int r = 0; r < W; r++) begin
            if (rot[r] == CODE) hit = 1'b1;
        end
    end

endmodule

// File: rtl/pdm_cmd_decode.sv
// Maps a locked window onto a command, independent of alignment.
module pdm_cmd_decode
    import pdm_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] win,
    output cmd_e             cmd
);

    logic [NUM_CODES-1:0] hit;

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        pdm_rot_match #(
            .W    (CMD_W),
            .CODE (CODE_TAB[i])
        ) u_match (
            .win (win),
            .hit (hit[i])
        );
    end

    always_comb begin
        cmd = CMD_NONE;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (hit[i]) cmd = cmd_e'(4'(i + 1));
        end
    end

endmodule

// File: rtl/pdm_repeat_detect.sv
// Counts consecutive bits equal to the bit W positions earlier.
module pdm_repeat_detect #(
    parameter int W          = 8,
    parameter int REPEAT_MIN = 129
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_lost,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic [W-1:0] win_next,
    output logic         lock_next,
    output logic         lock_q,
    output logic         entry
);

    localparam int THRESH = REPEAT_MIN * W - W;
    localparam int CNT_W  = $clog2(THRESH + 1);
    localparam int FILL_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]      hist;
        logic [FILL_W-1:0] fill;
        logic [CNT_W-1:0]  cnt;
        logic              lock;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        entry = 1'b0;
        if (!rst_n || clk_lost) begin
            st_d = '0;
        end else if (bit_valid) begin
            st_d.hist = {st_q.hist[W-2:0], bit_in};
            if (st_q.fill != FILL_W'(W)) begin
                st_d.fill = st_q.fill + 1'b1;
                st_d.cnt  = '0;
            end else if (bit_in == st_q.hist[W-1]) begin
                if (st_q.cnt != CNT_W'(THRESH)) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
            end
            st_d.lock = (st_d.cnt == CNT_W'(THRESH));
            entry     = st_d.lock && !st_q.lock;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign win_next  = st_d.hist;
    assign lock_next = st_d.lock;
    assign lock_q    = st_q.lock;

endmodule

// File: rtl/pdm_cfg_reg.sv
// Strap latch plus the command-driven configuration register.
module pdm_cfg_reg
    import pdm_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_lost,
    input  logic strap_gain_hi,
    input  logic strap_fs_hi,
    input  logic apply,
    input  cmd_e cmd,
    input  logic lock_next,
    output cfg_t cfg,
    output logic sleep_req
);

    typedef struct packed {
        logic strap_g;
        logic strap_f;
        cfg_t cfg;
        logic sleep;
    } reg_t;

    reg_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (!rst_n) begin
            rg_d.strap_g = strap_gain_hi;
            rg_d.strap_f = strap_fs_hi;
            rg_d.cfg     = strap_cfg(strap_gain_hi, strap_fs_hi);
            rg_d.sleep   = 1'b0;
        end else if (clk_lost) begin
            rg_d.cfg   = strap_cfg(rg_q.strap_g, rg_q.strap_f);
            rg_d.sleep = 1'b0;
        end else begin
            if (apply) begin
                case (cmd)
                    CMD_GAIN_3V6: rg_d.cfg.gain      = GAIN_3V6;
                    CMD_GAIN_2V5: rg_d.cfg.gain      = GAIN_2V5;
                    CMD_GAIN_5V0: rg_d.cfg.gain      = GAIN_5V0;
                    CMD_LOW_EMI:  rg_d.cfg.low_emi   = 1'b1;
                    CMD_LOW_LAT:  rg_d.cfg.low_lat   = 1'b1;
                    CMD_FS_FLIP:  rg_d.cfg.fs_hi     = ~rg_q.strap_f;
                    CMD_DEFAULTS: rg_d.cfg = strap_cfg(rg_q.strap_g, rg_q.strap_f);
                    CMD_MUTE:     rg_d.cfg.hold_mute = 1'b1;
                    default:      ;
                endcase
            end
            rg_d.sleep = lock_next && (rg_q.sleep || (apply && cmd == CMD_SLEEP));
        end
    end

    always_ff @(posedge clk) begin
        rg_q <= rg_d;
    end

    assign cfg       = rg_q.cfg;
    assign sleep_req = rg_q.sleep;

endmodule

// File: rtl/pdm_cmd_decoder.sv
module pdm_cmd_decoder
    import pdm_cmd_pkg::*;
#(
    parameter int REPEAT_MIN = 129
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_lost,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       strap_gain_hi,
    input  logic       strap_fs_hi,
    output logic [1:0] gain_sel,
    output logic       fs_hi,
    output logic       low_emi,
    output logic       low_lat,
    output logic       mute,
    output logic       sleep_req
);

    logic [CMD_W-1:0] win_next;
    logic             lock_next;
    logic             lock_q;
    logic             entry;
    cmd_e             cmd;
    cfg_t             cfg;

    pdm_repeat_detect #(
        .W          (CMD_W),
        .REPEAT_MIN (REPEAT_MIN)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_lost  (clk_lost),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .win_next  (win_next),
        .lock_next (lock_next),
        .lock_q    (lock_q),
        .entry     (entry)
    );

    pdm_cmd_decode u_decode (
        .win (win_next),
        .cmd (cmd)
    );

    pdm_cfg_reg u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_lost      (clk_lost),
        .strap_gain_hi (strap_gain_hi),
        .strap_fs_hi   (strap_fs_hi),
        .apply         (entry),
        .cmd           (cmd),
        .lock_next     (lock_next),
        .cfg           (cfg),
        .sleep_req     (sleep_req)
    );

    assign gain_sel = cfg.gain;
    assign fs_hi    = cfg.fs_hi;
    assign low_emi  = cfg.low_emi;
    assign low_lat  = cfg.low_lat;
    assign mute     = lock_q | cfg.hold_mute;

endmodule

// File: rtl/pdm_cmd_decoder_chk.sv
module pdm_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_lost,
    input logic       bit_valid,
    input logic [1:0] gain_sel,
    input logic       fs_hi,
    input logic       low_emi,
    input logic       low_lat,
    input logic       mute,
    input logic       sleep_req,
    input logic       lock_q
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !clk_lost) |=> $stable({gain_sel, fs_hi, low_emi, low_lat, mute, sleep_req})); // R2

    AST_LOCK_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> ($past(bit_valid) && !$past(clk_lost))); // R3

    AST_LOCK_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> ($past(bit_valid) || $past(clk_lost))); // R3

    AST_CFG_ONLY_AT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({gain_sel, fs_hi, low_emi, low_lat}) |-> ($past(clk_lost) || $rose(lock_q))); // R4

    AST_SLEEP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (lock_q && mute)); // R9

    AST_CLKLOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lost |=> (!low_emi && !low_lat && !mute && !sleep_req)); // R11

endmodule

bind pdm_cmd_decoder pdm_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_lost  (clk_lost),
    .bit_valid (bit_valid),
    .gain_sel  (gain_sel),
    .fs_hi     (fs_hi),
    .low_emi   (low_emi),
    .low_lat   (low_lat),
    .mute      (mute),
    .sleep_req (sleep_req),
    .lock_q    (lock_q)
);

// File: tb/pdm_cmd_decoder_tb.sv
`timescale 1ns/1ps
module pdm_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int THRESH     = 129 * 8 - 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_lost = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic strap_gain_hi = 1'b0;
    logic strap_fs_hi = 1'b0;
    logic [1:0] gain_sel;
    logic fs_hi, low_emi, low_lat, mute, sleep_req;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pdm_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .clk_lost(clk_lost), .bit_valid(bit_valid),
        .bit_in(bit_in), .strap_gain_hi(strap_gain_hi), .strap_fs_hi(strap_fs_hi),
        .gain_sel(gain_sel), .fs_hi(fs_hi), .low_emi(low_emi), .low_lat(low_lat),
        .mute(mute), .sleep_req(sleep_req)
    );

    typedef struct {
        string      tag;
        logic [1:0] gain;
        logic       fs, emi, lat, mt, slp;
    } exp_t;

    exp_t  sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // Reference model state, built from the requirements
    logic [7:0] m_hist;
    int         m_fill, m_cnt;
    logic       m_lock, m_sg, m_sf;
    logic [1:0] m_gain;
    logic       m_fs, m_emi, m_lat, m_hmute, m_sleep;

    function automatic int decode(input logic [7:0] w);
        logic [7:0] r;
        int c = 0;
        for (int k = 0; k < 8; k++) begin
            r = (k == 0) ? w : ((w << k) | (w >> (8 - k)));
            case (r)
                8'hD2: c = 1;  8'hD4: c = 2;  8'hD8: c = 3;
                8'hE1: c = 4;  8'hE2: c = 5;  8'hE4: c = 6;
                8'hAA: c = 7;  8'h66: c = 8;  8'hAC: c = 9;
                default: ;
            endcase
        end
        return c;
    endfunction

    task automatic model_defaults();
        m_gain = m_sg ? 2'd2 : 2'd0;
        m_fs = m_sf; m_emi = 1'b0; m_lat = 1'b0; m_hmute = 1'b0;
    endtask

    task automatic model_flush();
        m_hist = '0; m_fill = 0; m_cnt = 0; m_lock = 1'b0; m_sleep = 1'b0;
    endtask

    task automatic model_bit(input logic b);
        logic was;
        int c;
        was = m_lock;
        if (m_fill < 8) begin
            m_fill++; m_cnt = 0;
        end else if (b == m_hist[7]) begin
            if (m_cnt < THRESH) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        m_hist = {m_hist[6:0], b};
        m_lock = (m_cnt == THRESH);
        if (m_lock && !was) begin
            c = decode(m_hist);
            case (c)
                1: m_gain = 2'd0;
                2: m_gain = 2'd1;
                3: m_gain = 2'd2;
                4: m_emi = 1'b1;
                5: m_lat = 1'b1;
                6: m_fs = ~m_sf;
                7: model_defaults();
                8: m_hmute = 1'b1;
                default: ;
            endcase
            m_sleep = (c == 9);
        end else begin
            m_sleep = m_lock && m_sleep;
        end
    endtask

    task automatic push_exp();
        exp_t e;
        e.tag = cur_tag; e.gain = m_gain; e.fs = m_fs; e.emi = m_emi;
        e.lat = m_lat; e.mt = m_lock | m_hmute; e.slp = m_sleep;
        sb_q.push_back(e);
    endtask

    // Monitor: pops one expected item per cycle and compares at the ports
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if ({gain_sel, fs_hi, low_emi, low_lat, mute, sleep_req} !==
                {e.gain, e.fs, e.emi, e.lat, e.mt, e.slp}) begin
                n_bad++;
                $display("FAIL %s: got gain=%0d fs=%0b emi=%0b lat=%0b mute=%0b sleep=%0b, expected gain=%0d fs=%0b emi=%0b lat=%0b mute=%0b sleep=%0b",
                         e.tag, gain_sel, fs_hi, low_emi, low_lat, mute, sleep_req,
                         e.gain, e.fs, e.emi, e.lat, e.mt, e.slp);
            end
        end
    end

    task automatic dchk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d, expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1; bit_in = b;
        model_bit(b);
        @(posedge clk);
        #1 bit_valid = 1'b0;
        push_exp();
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            @(posedge clk);
            #1 push_exp();
        end
    endtask

    task automatic send_word(input logic [7:0] w, input int n);
        repeat (n) begin
            for (int i = 7; i >= 0; i--) send_bit(w[i]);
        end
    endtask

    task automatic break_run();
        send_bit(~m_hist[7]);
        idle(2);
    endtask

    task automatic lose_clock(input logic with_bit);
        @(negedge clk);
        clk_lost = 1'b1; bit_valid = with_bit; bit_in = 1'b1;
        @(posedge clk);
        #1 clk_lost = 1'b0; bit_valid = 1'b0;
        model_flush(); model_defaults();
        push_exp();
    endtask

    task automatic power_on(input logic g, input logic f);
        @(negedge clk);
        rst_n = 1'b0; strap_gain_hi = g; strap_fs_hi = f;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_sg = g; m_sf = f;
        model_flush(); model_defaults();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected finish before timeout");
        summary();
        $finish;
    end

    initial begin
        // R1: defaults from straps, latched at reset
        power_on(1'b1, 1'b0);
        @(negedge clk);
        dchk("R1", "gain_sel", gain_sel, 2);
        dchk("R1", "fs_hi", fs_hi, 0);
        dchk("R1", "low_emi", low_emi, 0);
        dchk("R1", "low_lat", low_lat, 0);
        dchk("R1", "mute", mute, 0);
        dchk("R1", "sleep_req", sleep_req, 0);
        strap_gain_hi = 1'b0; strap_fs_hi = 1'b1;
        cur_tag = "R1"; idle(3);
        @(negedge clk);
        dchk("R1", "gain after strap change", gain_sel, 2);
        dchk("R1", "fs after strap change", fs_hi, 0);

        // R4: gain code 0xD2
        cur_tag = "R4";
        send_word(8'hD2, 130); break_run();
        @(negedge clk);
        dchk("R4", "gain after 0xD2", gain_sel, 0);

        // R11: clock loss restores defaults
        cur_tag = "R11";
        lose_clock(1'b0);
        @(negedge clk);
        dchk("R11", "gain after clock loss", gain_sel, 2);

        // R3: exact lock boundary from an empty history
        cur_tag = "R3";
        send_word(8'hD4, 128);
        @(negedge clk);
        dchk("R3", "mute after 128 words", mute, 0);
        dchk("R3", "gain after 128 words", gain_sel, 2);
        send_word(8'hD4, 1);
        @(negedge clk);
        dchk("R3", "mute after 129 words", mute, 1);
        dchk("R3", "gain after 129 words", gain_sel, 1);
        send_bit(~m_hist[7]);
        @(negedge clk);
        dchk("R3", "mute after first mismatch", mute, 0);
        idle(2);

        // R4 + R2: misaligned start and idle gaps inside the pattern
        cur_tag = "R2";
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        for (int k = 0; k < 131; k++) begin
            send_word(8'hD2, 1);
            if (k % 16 == 0) idle(3);
        end
        break_run();
        @(negedge clk);
        dchk("R4", "gain after misaligned 0xD2", gain_sel, 0);

        // R5 and R12
        cur_tag = "R5";
        send_word(8'hE1, 130); break_run();
        send_word(8'hE2, 130); break_run();
        @(negedge clk);
        dchk("R5", "low_emi", low_emi, 1);
        dchk("R5", "low_lat", low_lat, 1);
        dchk("R12", "gain kept", gain_sel, 0);

        // R6: sample-rate flip against latched strap
        cur_tag = "R6";
        send_word(8'hE4, 130); break_run();
        @(negedge clk);
        dchk("R6", "fs_hi flipped", fs_hi, 1);

        cur_tag = "R12";
        send_word(8'hD8, 130); break_run();
        @(negedge clk);
        dchk("R12", "gain 5V", gain_sel, 2);
        dchk("R12", "low_emi kept", low_emi, 1);
        dchk("R12", "fs kept", fs_hi, 1);

        // R10: unknown word
        cur_tag = "R10";
        send_word(8'h3A, 130);
        @(negedge clk);
        dchk("R10", "mute during unknown word", mute, 1);
        break_run();
        @(negedge clk);
        dchk("R10", "gain unchanged", gain_sel, 2);
        dchk("R10", "low_lat unchanged", low_lat, 1);
        dchk("R10", "mute released", mute, 0);

        // R8: held mute
        cur_tag = "R8";
        send_word(8'h66, 130); break_run(); idle(5);
        @(negedge clk);
        dchk("R8", "held mute", mute, 1);

        // R7: restore defaults
        cur_tag = "R7";
        send_word(8'hAA, 130); break_run();
        @(negedge clk);
        dchk("R7", "gain", gain_sel, 2);
        dchk("R7", "fs_hi", fs_hi, 0);
        dchk("R7", "low_emi", low_emi, 0);
        dchk("R7", "low_lat", low_lat, 0);
        dchk("R7", "mute", mute, 0);

        // R9: power-down request
        cur_tag = "R9";
        send_word(8'hAC, 130);
        @(negedge clk);
        dchk("R9", "sleep_req while repeating", sleep_req, 1);
        dchk("R9", "mute while repeating", mute, 1);
        send_bit(~m_hist[7]);
        @(negedge clk);
        dchk("R9", "sleep_req after mismatch", sleep_req, 0);
        idle(2);

        // R11: clock loss during a held mute and a live pattern, with a bit present
        cur_tag = "R11";
        send_word(8'hE1, 130); break_run();
        send_word(8'h66, 130);
        lose_clock(1'b1);
        @(negedge clk);
        dchk("R11", "mute cleared", mute, 0);
        dchk("R11", "low_emi cleared", low_emi, 0);
        dchk("R11", "sleep_req", sleep_req, 0);
        idle(2);

        // R1: second power-up with other straps
        cur_tag = "R1";
        power_on(1'b0, 1'b1);
        @(negedge clk);
        dchk("R1", "gain after re-strap", gain_sel, 0);
        dchk("R1", "fs after re-strap", fs_hi, 1);
        idle(2);
        @(negedge clk);
        summary();
        $finish;
    end

endmodule